// File: doc/BRIEF.md
# Power-Good Timeout Supervisor

This block produces the active-high power-good signal of a multi-rail power controller. That signal releases system reset. Each rail has two flags: a good flag, which says the rail's output is above 92.5% of its input (an upstream comparator with about 0.5% hysteresis generates it), and an undervoltage-OK flag. A global enable-OK flag and a fault flag from the rail controller complete the inputs. Power-good rises only after every rail has stayed good, without a break, for a programmable timeout. The timeout is a base delay (200 µs at 50 MHz by default) plus a programmed extension.

Power-good drops at once when supply conditions are lost. If a rail falls out of regulation while power-good is high, the block raises a one-cycle request for fast shutdown.

An active-low margin input freezes the block for system-level testing. While margin is active, power-good and the registered fault output keep their values and all monitoring stops. When margin is released, the timeout qualification starts again from the present conditions.

Top module: `pg_supervisor`

## Requirements
- R1: While reset is applied and on the first cycle after it, `pwr_good`, `fault_out` and `shutdown_req` are all 0.
- R2: When all `chan_good` bits are 1, all `uv_ok` bits are 1, `en_ok` is 1, `fault_in` is 0 and `margin_n` is 1, the block is qualified. `pwr_good` goes to 1 at the LIMIT-th consecutive qualified rising edge, where LIMIT = BASE_CYC + `timeout_ext` × EXT_UNIT. Before that edge it stays 0.
- R3: If any `chan_good` bit drops for even one cycle before the timeout expires, the count restarts. After the condition returns, a full LIMIT qualified edges are needed again.
- R4: If any `uv_ok` bit or `en_ok` is 0 while `margin_n` is 1, `pwr_good` is 0 after the next edge and `shutdown_req` stays 0.
- R5: If `pwr_good` is 1, supply conditions are intact and any `chan_good` bit is 0, then after the next edge `pwr_good` is 0 and `shutdown_req` is 1. The request lasts exactly one cycle.
- R6: `fault_out` equals `fault_in` delayed by one edge while not margined. While `fault_in` is 1, `pwr_good` is 0 after the next edge.
- R7: While `margin_n` is 0, `pwr_good` and `fault_out` keep their values and `shutdown_req` stays 0. Changes on `chan_good`, `uv_ok`, `en_ok` and `fault_in` have no effect on them.
- R8: After `margin_n` returns to 1 with `pwr_good` at 0, qualification starts from zero. `pwr_good` rises at the LIMIT-th qualified edge counted from the first edge with `margin_n` high, regardless of any qualified time before the margin period.
- R9: With `timeout_ext` = 0 the delay is exactly BASE_CYC edges, the default timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_good | input | NCH | Per-rail flag: output above 92.5% of input |
| uv_ok | input | NCH | Per-rail flag: input above its undervoltage threshold |
| en_ok | input | 1 | Enable input above its threshold |
| fault_in | input | 1 | Fault flag from the rail controller |
| margin_n | input | 1 | Margin request, active low |
| timeout_ext | input | EXT_W | Programmed timeout extension, in units of EXT_UNIT cycles |
| pwr_good | output | 1 | Power-good / reset release, active high |
| fault_out | output | 1 | Registered fault flag, frozen during margin |
| shutdown_req | output | 1 | One-cycle fast-shutdown request |

## Verification
The assertions assume that `timeout_ext` holds steady while a qualification is running. They also assume the flags are already synchronous to `clk`, so a level seen at one edge reflects the real rail state. The bench writes `timeout_ext` only while the block is in reset or before a qualification starts. It changes every flag half a cycle away from the active edge. Each flag moves by whole cycles, so every dropout and every margin window has a known edge count.

// File: rtl/pg_sup_pkg.sv
package pg_sup_pkg;

   // Condition summary passed from the qualifier to the timer and output stage.
   typedef struct packed {
      logic supply_ok;   // every undervoltage flag, enable, and no fault
      logic all_good;    // every rail above its good fraction
      logic qual;        // both of the above
   } pg_cond_t;

   function automatic int unsigned pg_lim_max(input int unsigned base,
                                              input int unsigned ext_w,
                                              input int unsigned unit);
      return base + (((1 << ext_w) - 1) * unit);
   endfunction

endpackage

// File: rtl/pg_qualify.sv
module pg_qualify
   import pg_sup_pkg::*;
#(
   parameter int unsigned NCH = 3
) (
   input  logic [NCH-1:0] chan_good,
   input  logic [NCH-1:0] uv_ok,
   input  logic           en_ok,
   input  logic           fault_in,
   output pg_cond_t       cond
);

   if (NCH < 1) begin : g_bad_nch
      $error("pg_qualify: NCH must be at least 1");
   end

   always_comb begin
      cond.supply_ok = (&uv_ok) & en_ok & ~fault_in;
      cond.all_good  = &chan_good;
      cond.qual      = cond.supply_ok & cond.all_good;
   end

endmodule

// File: rtl/pg_timer.sv
module pg_timer
   import pg_sup_pkg::*;
#(
   parameter int unsigned BASE_CYC = 10000,
   parameter int unsigned EXT_W    = 8,
   parameter int unsigned EXT_UNIT = 1024,
   localparam int unsigned LIM_MAX = pg_lim_max(BASE_CYC, EXT_W, EXT_UNIT),
   localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [EXT_W-1:0] timeout_ext,
   output logic             done
);

   localparam bit UNIT_POW2 = ((EXT_UNIT & (EXT_UNIT - 1)) == 0);
   localparam int unsigned UNIT_SH = (EXT_UNIT > 1) ? $clog2(EXT_UNIT) : 0;

   if (BASE_CYC < 1) begin : g_bad_base
      $error("pg_timer: BASE_CYC must be at least 1");
   end
   if (EXT_UNIT < 1) begin : g_bad_unit
      $error("pg_timer: EXT_UNIT must be at least 1");
   end

   logic [CNT_W-1:0] ext_cyc;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] cnt;

   // Extension scaling: a shift when the unit is a power of two, a multiply otherwise.
   if (UNIT_POW2) begin : g_ext_shift
      assign ext_cyc = CNT_W'(timeout_ext) << UNIT_SH;
   end else begin : g_ext_mult
      assign ext_cyc = CNT_W'(timeout_ext) * CNT_W'(EXT_UNIT);
   end

   assign last = CNT_W'(BASE_CYC) + ext_cyc - CNT_W'(1);
   assign done = run & (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (cnt < last)
         cnt <= cnt + CNT_W'(1);
   end

   // R3
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(timeout_ext) |-> (cnt <= last));

endmodule

// File: rtl/pg_outstage.sv
module pg_outstage
   import pg_sup_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pg_cond_t cond,
   input  logic     margin_n,
   input  logic     fault_in,
   input  logic     done,
   output logic     pwr_good,
   output logic     fault_out,
   output logic     shutdown_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_good     <= 1'b0;
         fault_out    <= 1'b0;
         shutdown_req <= 1'b0;
      end else begin
         shutdown_req <= 1'b0;
         if (margin_n) begin
            fault_out <= fault_in;
            if (!cond.supply_ok) begin
               pwr_good <= 1'b0;
            end else if (!cond.all_good) begin
               shutdown_req <= pwr_good;
               pwr_good     <= 1'b0;
            end else if (done) begin
               pwr_good <= 1'b1;
            end
         end
      end
   end

   // R2
   pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_good) |-> $past(cond.qual && margin_n && done));

   // R4
   supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (margin_n && !cond.supply_ok) |=> (!pwr_good && !shutdown_req));

   // R5
   shut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> (!pwr_good && $past(pwr_good)));

   // R6
   fault_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      margin_n |=> (fault_out == $past(fault_in)));

   // R7
   margin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !margin_n |=> ($stable(pwr_good) && $stable(fault_out) && !shutdown_req));

endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor
   import pg_sup_pkg::*;
#(
   parameter int unsigned NCH      = 3,
   parameter int unsigned BASE_CYC = 10000,
   parameter int unsigned EXT_W    = 8,
   parameter int unsigned EXT_UNIT = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   chan_good,
   input  logic [NCH-1:0]   uv_ok,
   input  logic             en_ok,
   input  logic             fault_in,
   input  logic             margin_n,
   input  logic [EXT_W-1:0] timeout_ext,
   output logic             pwr_good,
   output logic             fault_out,
   output logic             shutdown_req
);

   if (EXT_W < 1 || EXT_W > 16) begin : g_bad_extw
      $error("pg_supervisor: EXT_W must lie in 1..16");
   end

   pg_cond_t cond;
   logic     run;
   logic     done;

   pg_qualify #(.NCH(NCH)) i_qual (
      .chan_good (chan_good),
      .uv_ok     (uv_ok),
      .en_ok     (en_ok),
      .fault_in  (fault_in),
      .cond      (cond)
   );

   // The timer runs only while qualified, unmargined and not yet good.
   assign run = cond.qual & margin_n & ~pwr_good;

   pg_timer #(
      .BASE_CYC (BASE_CYC),
      .EXT_W    (EXT_W),
      .EXT_UNIT (EXT_UNIT)
   ) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .timeout_ext (timeout_ext),
      .done        (done)
   );

   pg_outstage i_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond         (cond),
      .margin_n     (margin_n),
      .fault_in     (fault_in),
      .done         (done),
      .pwr_good     (pwr_good),
      .fault_out    (fault_out),
      .shutdown_req (shutdown_req)
   );

endmodule

// File: tb/test_pg_supervisor.sv
`timescale 1ns/1ps
module test_pg_supervisor;

   localparam int NCH  = 3;
   localparam int BASE = 8;
   localparam int EXTW = 4;
   localparam int UNIT = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NCH-1:0]  chan_good;
   logic [NCH-1:0]  uv_ok;
   logic            en_ok;
   logic            fault_in;
   logic            margin_n;
   logic [EXTW-1:0] timeout_ext;
   logic            pwr_good;
   logic            fault_out;
   logic            shutdown_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pg_supervisor #(
      .NCH(NCH), .BASE_CYC(BASE), .EXT_W(EXTW), .EXT_UNIT(UNIT)
   ) i_pg_supervisor (
      .clk(clk), .rst_n(rst_n), .chan_good(chan_good), .uv_ok(uv_ok),
      .en_ok(en_ok), .fault_in(fault_in), .margin_n(margin_n),
      .timeout_ext(timeout_ext), .pwr_good(pwr_good),
      .fault_out(fault_out), .shutdown_req(shutdown_req)
   );

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic all_ok();
      chan_good = '1; uv_ok = '1; en_ok = 1'b1; fault_in = 1'b0; margin_n = 1'b1;
   endtask

   task automatic do_reset(input logic [EXTW-1:0] ext);
      @(negedge clk);
      rst_n = 1'b0;
      chan_good = '0; uv_ok = '0; en_ok = 1'b0; fault_in = 1'b0; margin_n = 1'b1;
      timeout_ext = ext;
      edges(2);
      rst_n = 1'b1;
   endtask

   // Qualify and land exactly on the edge where power-good rises.
   task automatic reach_good(input int lim, input string req);
      all_ok();
      edges(lim - 1);
      chk(req, "pg before limit", pwr_good, 1'b0);
      edges(1);
      chk(req, "pg at limit", pwr_good, 1'b1);
   endtask

   task automatic t_reset();
      do_reset(4'd0);
      chk("R1", "pg in reset", pwr_good, 1'b0);
      edges(1);
      chk("R1", "pg after reset", pwr_good, 1'b0);
      chk("R1", "fault after reset", fault_out, 1'b0);
      chk("R1", "shutdown after reset", shutdown_req, 1'b0);
   endtask

   task automatic t_default_timeout();
      do_reset(4'd0);
      reach_good(BASE, "R9");
   endtask

   task automatic t_extended_timeout();
      do_reset(4'd2);
      reach_good(BASE + 2 * UNIT, "R2");
      edges(3);
      chk("R2", "pg stays high", pwr_good, 1'b1);
   endtask

   task automatic t_dropout_restart();
      do_reset(4'd0);
      all_ok();
      edges(5);
      chan_good[1] = 1'b0;
      edges(1);
      chk("R3", "pg low during dropout", pwr_good, 1'b0);
      reach_good(BASE, "R3");
   endtask

   task automatic t_supply_drop();
      do_reset(4'd0);
      reach_good(BASE, "R4");
      uv_ok[2] = 1'b0;
      edges(1);
      chk("R4", "pg after uv drop", pwr_good, 1'b0);
      chk("R4", "no shutdown on uv drop", shutdown_req, 1'b0);
      uv_ok[2] = 1'b1;
      reach_good(BASE, "R4");
      en_ok = 1'b0;
      edges(1);
      chk("R4", "pg after enable drop", pwr_good, 1'b0);
      chk("R4", "no shutdown on enable drop", shutdown_req, 1'b0);
   endtask

   task automatic t_fast_shutdown();
      do_reset(4'd0);
      reach_good(BASE, "R5");
      chan_good[2] = 1'b0;
      edges(1);
      chk("R5", "pg after rail drop", pwr_good, 1'b0);
      chk("R5", "shutdown pulse", shutdown_req, 1'b1);
      edges(1);
      chk("R5", "shutdown one cycle", shutdown_req, 1'b0);
   endtask

   task automatic t_fault();
      do_reset(4'd0);
      reach_good(BASE, "R6");
      fault_in = 1'b1;
      edges(1);
      chk("R6", "pg on fault", pwr_good, 1'b0);
      chk("R6", "fault_out follows", fault_out, 1'b1);
      chk("R6", "no shutdown on fault", shutdown_req, 1'b0);
      fault_in = 1'b0;
      edges(1);
      chk("R6", "fault_out clears", fault_out, 1'b0);
   endtask

   task automatic t_margin_hold();
      do_reset(4'd0);
      reach_good(BASE, "R7");
      margin_n = 1'b0;
      edges(1);
      chan_good = '0; uv_ok = '0; fault_in = 1'b1;
      edges(3);
      chk("R7", "pg held in margin", pwr_good, 1'b1);
      chk("R7", "fault held in margin", fault_out, 1'b0);
      chk("R7", "no shutdown in margin", shutdown_req, 1'b0);
   endtask

   task automatic t_margin_restart();
      do_reset(4'd0);
      all_ok();
      edges(5);
      margin_n = 1'b0;
      edges(BASE + 4);
      chk("R7", "pg held low in margin", pwr_good, 1'b0);
      margin_n = 1'b1;
      reach_good(BASE, "R8");
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      chan_good = '0; uv_ok = '0; en_ok = 1'b0; fault_in = 1'b0;
      margin_n = 1'b1; timeout_ext = '0;
      t_reset();
      t_default_timeout();
      t_extended_timeout();
      t_dropout_restart();
      t_supply_drop();
      t_fast_shutdown();
      t_fault();
      t_margin_hold();
      t_margin_restart();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule